// File: doc/BRIEF.md
# PWM Control Input Event Conditioner

This block conditions one external event for a PWM generator. A source is picked from a small vector of candidate signals. Candidates can include another generator's output, a device pin, or a comparator or converter flag. The picked source can be inverted, and it then passes through a clock-domain synchronizer. When a source qualifier allows it, the synchronized source sets a single "active" output. That output stays set until a terminator event arrives while its own qualifier is high.

The block has two paths for its output. The registered active output, together with a one-clock trigger pulse taken from the rising edge of the synchronized source, serves trigger and gating logic inside the PWM clock domain. Because of the synchronizer, trigger timing is uncertain by one or two clocks. A separate unclocked bypass output carries the qualified raw source straight through, so pin-override logic can react without waiting for a clock.

Status is reported as the present active level and as a sticky flag. Software clears the sticky flag by writing a one. An interrupt request pulses when the active output is entered. A global enable input gates all of this.

Top module: `pwm_evt_cond`

## Requirements
- R1: The candidate chosen is `srcVec[srcSel]` (bit index equals the select value). When `srcInvert` is 1 that bit is inverted. The result then passes through two flip-flops before the acceptance logic uses it, so a source change seen before edge k is acted on at edge k+2. Bits that are not selected have no effect.
- R2: At a clock edge where the synchronized source is 1 and `srcQual` is 1, `activeOut` becomes 1. While `srcQual` is 0 the source has no effect.
- R3: Once set, `activeOut` stays 1 until an edge where both `termEvent` and `termQual` are 1. A terminator event while `termQual` is 0 has no effect.
- R4: When a qualified set and a qualified terminate happen at the same edge, `activeOut` ends at 0.
- R5: `trigPulse` is 1 for exactly one clock after each rising edge of the synchronized source, and only while `srcQual` and `enable` are 1.
- R6: `bypassOut` equals `enable & (selected source after inversion) & srcQual`, with no clock in between.
- R7: `statusLatched` becomes 1 at the edge after any cycle in which `activeOut` is 1. It stays 1 until an edge where `statClear` is 1 and `activeOut` is 0.
- R8: `irq` is 1 for exactly the first clock cycle in which `activeOut` is 1.
- R9: While `enable` is 0, `activeOut`, `irq`, `trigPulse` and `bypassOut` are 0. `activeOut` is cleared at the first edge with `enable` at 0.
- R10: After reset (`rstN` low) all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| srcVec | input | NUM_SRC | Candidate source signals |
| srcSel | input | SEL_W | Index of the source used |
| srcInvert | input | 1 | Invert the chosen source |
| srcQual | input | 1 | Source qualifier |
| termEvent | input | 1 | Terminator event |
| termQual | input | 1 | Terminator qualifier |
| statClear | input | 1 | Write-one clear of the sticky flag |
| activeOut | output | 1 | Active output / present status |
| statusLatched | output | 1 | Sticky status flag |
| irq | output | 1 | Interrupt request pulse |
| trigPulse | output | 1 | One-clock synchronized trigger |
| bypassOut | output | 1 | Unclocked qualified source |

## Verification
The bench builds the block with eight sources and a two-stage synchronizer. This makes the full three-bit select range reachable, including the end index and a middle index. It also fixes the set latency at a known two edges, so a cycle model can predict `activeOut`, `trigPulse`, `irq` and the sticky flag on every clock. The chosen sequences drive inversion, a qualifier held low, an unqualified terminator, a set and terminate at the same edge, a clear while the output is active, and enable dropped while the output is active.

// File: rtl/pwm_evt_cond_pkg.sv
package pwm_evt_cond_pkg;

  // Acceptance state of the event conditioner
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } evtState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic enter;  // active output is being entered this edge
    logic leave;  // active output is being left this edge
  } ctlStrobe_t;

endpackage

// File: rtl/pwm_evt_datapath.sv
module pwm_evt_datapath
  import pwm_evt_cond_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LAST       = SYNC_STAGES - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [NUM_SRC-1:0] srcVec,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               srcInvert,
  input  logic               srcQual,
  input  logic               statClear,
  input  logic               activeOut,
  input  ctlStrobe_t         strobe,
  output logic               syncLevel,
  output logic               trigPulse,
  output logic               bypassOut,
  output logic               statusLatched,
  output logic               irq
);

  logic                   selBit;
  logic                   srcLevel;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;
  logic                   latchedQ;
  logic                   irqQ;

  // Source multiplexer: one compare per candidate
  always_comb begin
    selBit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcSel == SEL_W'(i)) selBit = srcVec[i];
    end
  end

  assign srcLevel = selBit ^ srcInvert;

  // Synchronizer chain into the PWM clock domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= srcLevel;
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign syncLevel = syncChain[LAST];

  // Edge detector for the trigger path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncLevel;
  end

  assign trigPulse = syncLevel & ~prevLevel & srcQual & enable;

  // Fast path: no register between source and output
  assign bypassOut = enable & srcLevel & srcQual;

  // Sticky status flag, write-one clear, active level wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchedQ <= 1'b0;
    else       latchedQ <= (latchedQ & ~statClear) | activeOut;
  end

  // Interrupt request on entry into the active state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strobe.enter & ~strobe.leave;
  end

  assign statusLatched = latchedQ;
  assign irq           = irqQ;

endmodule

// File: rtl/pwm_evt_control.sv
module pwm_evt_control
  import pwm_evt_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       syncLevel,
  input  logic       srcQual,
  input  logic       termEvent,
  input  logic       termQual,
  output ctlStrobe_t strobe,
  output logic       activeOut
);

  evtState_t state;
  evtState_t stateNext;
  logic      setHit;
  logic      termHit;

  assign setHit  = syncLevel & srcQual;
  assign termHit = termEvent & termQual;

  // Terminate beats set; disable beats everything
  always_comb begin
    stateNext    = state;
    strobe.enter = 1'b0;
    strobe.leave = 1'b0;
    if (!enable) begin
      stateNext    = ST_IDLE;
      strobe.leave = (state == ST_ACTIVE);
    end else begin
      case (state)
        ST_IDLE: begin
          if (setHit && !termHit) begin
            stateNext    = ST_ACTIVE;
            strobe.enter = 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (termHit) begin
            stateNext    = ST_IDLE;
            strobe.leave = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign activeOut = (state == ST_ACTIVE);

endmodule

// File: rtl/pwm_evt_cond.sv
module pwm_evt_cond
  import pwm_evt_cond_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [NUM_SRC-1:0] srcVec,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               srcInvert,
  input  logic               srcQual,
  input  logic               termEvent,
  input  logic               termQual,
  input  logic               statClear,
  output logic               activeOut,
  output logic               statusLatched,
  output logic               irq,
  output logic               trigPulse,
  output logic               bypassOut
);

  ctlStrobe_t strobe;
  logic       syncLevel;
  logic       activeInt;

  pwm_evt_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .syncLevel (syncLevel),
    .srcQual   (srcQual),
    .termEvent (termEvent),
    .termQual  (termQual),
    .strobe    (strobe),
    .activeOut (activeInt)
  );

  pwm_evt_datapath #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .srcVec        (srcVec),
    .srcSel        (srcSel),
    .srcInvert     (srcInvert),
    .srcQual       (srcQual),
    .statClear     (statClear),
    .activeOut     (activeInt),
    .strobe        (strobe),
    .syncLevel     (syncLevel),
    .trigPulse     (trigPulse),
    .bypassOut     (bypassOut),
    .statusLatched (statusLatched),
    .irq           (irq)
  );

  assign activeOut = activeInt;

endmodule

// File: rtl/pwm_evt_cond_chk.sv
module pwm_evt_cond_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic termEvent,
  input logic termQual,
  input logic activeOut,
  input logic statusLatched,
  input logic irq,
  input logic trigPulse,
  input logic bypassOut
);

  // R3
  term_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeOut && enable && !(termEvent && termQual)) |=> activeOut);

  // R4
  term_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termEvent && termQual) |=> !activeOut);

  // R5
  trig_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R7
  latch_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeOut |=> statusLatched);

  // R8
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(activeOut) |-> irq);

  // R8
  irq_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> activeOut);

  // R9
  enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!activeOut && !irq));

  // R9
  bypass_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!bypassOut && !trigPulse));

endmodule

bind pwm_evt_cond pwm_evt_cond_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .enable        (enable),
  .termEvent     (termEvent),
  .termQual      (termQual),
  .activeOut     (activeOut),
  .statusLatched (statusLatched),
  .irq           (irq),
  .trigPulse     (trigPulse),
  .bypassOut     (bypassOut)
);

// File: tb/pwm_evt_cond_tb.sv
module pwm_evt_cond_tb;

  localparam int CLK_P   = 10;
  localparam int NUM_SRC = 8;
  localparam int SEL_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [NUM_SRC-1:0] srcVec = '0;
  logic [SEL_W-1:0] srcSel = '0;
  logic srcInvert = 1'b0, srcQual = 1'b0, termEvent = 1'b0, termQual = 1'b0, statClear = 1'b0;
  logic activeOut, statusLatched, irq, trigPulse, bypassOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic act;
    logic lat;
    logic irq;
    logic trig;
  } exp_t;

  exp_t expQ[$];
  exp_t monE;

  // cycle model state
  logic mS1 = 0, mS2 = 0, mAct = 0, mLat = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_evt_cond #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .srcVec(srcVec), .srcSel(srcSel),
    .srcInvert(srcInvert), .srcQual(srcQual), .termEvent(termEvent),
    .termQual(termQual), .statClear(statClear), .activeOut(activeOut),
    .statusLatched(statusLatched), .irq(irq), .trigPulse(trigPulse),
    .bypassOut(bypassOut)
  );

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Driver: predicts the state after the coming edge and pushes it
  task automatic tick();
    logic selv, setHit, termHit, nAct, nLat, nIrq, nTrig;
    selv    = srcVec[srcSel] ^ srcInvert;           // R1 select and invert
    setHit  = mS2 & srcQual;                        // R2
    termHit = termEvent & termQual;                 // R3
    nAct    = enable ? (termHit ? 1'b0 : (setHit ? 1'b1 : mAct)) : 1'b0; // R4 R9
    nIrq    = nAct & ~mAct;                         // R8
    nLat    = (mLat & ~statClear) | mAct;           // R7
    nTrig   = mS1 & ~mS2 & srcQual & enable;        // R5
    mS2 = mS1; mS1 = selv; mAct = nAct; mLat = nLat;
    expQ.push_back('{act: nAct, lat: nLat, irq: nIrq, trig: nTrig});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic checkBypass(input logic exp);
    #1;
    check1("R6 bypassOut", bypassOut, exp);
  endtask

  // Monitor: pops and compares after every edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (expQ.size() > 0) begin
      monE = expQ.pop_front();
      check1("R2 R3 R4 R9 activeOut", activeOut, monE.act);
      check1("R7 statusLatched", statusLatched, monE.lat);
      check1("R8 irq", irq, monE.irq);
      check1("R5 trigPulse", trigPulse, monE.trig);
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check1("R10 activeOut", activeOut, 1'b0);
    check1("R10 statusLatched", statusLatched, 1'b0);
    check1("R10 irq", irq, 1'b0);
    check1("R10 trigPulse", trigPulse, 1'b0);
    check1("R10 bypassOut", bypassOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R5 R8: select index 3, qualified
    enable = 1; srcSel = 3; srcQual = 1;
    srcVec = 8'b0000_1000;
    checkBypass(1'b1);
    ticks(5);

    // R3: source gone, active holds; unqualified terminator ignored
    srcVec = 8'h00;
    checkBypass(1'b0);
    ticks(3);
    termEvent = 1; termQual = 0;
    ticks(2);
    termQual = 1;
    ticks(2);
    termEvent = 0; termQual = 0;

    // R7: clear with active low
    ticks(1);
    statClear = 1;
    ticks(2);
    statClear = 0;
    ticks(1);

    // R1: non-selected bit ignored
    srcSel = 0; srcVec = 8'b1111_1110;
    checkBypass(1'b0);
    ticks(4);

    // R2: qualifier low blocks set
    srcVec = 8'b0000_0001; srcQual = 0;
    checkBypass(1'b0);
    ticks(4);
    srcQual = 1;
    checkBypass(1'b1);
    ticks(4);

    // R7: clear while active keeps the flag
    statClear = 1;
    ticks(2);
    statClear = 0;

    // R9: enable low while active
    enable = 0;
    checkBypass(1'b0);
    ticks(3);
    enable = 1;
    ticks(2);
    termEvent = 1; termQual = 1;
    ticks(1);
    termEvent = 0; termQual = 0;

    // R1 R4: inverted index 7, set and terminate at the same edge
    srcVec = 8'h00; srcSel = 7; srcInvert = 1;
    ticks(1);
    termEvent = 1; termQual = 1;
    ticks(4);
    termEvent = 0; termQual = 0;
    ticks(2);
    srcVec = 8'h80;
    checkBypass(1'b0);
    ticks(4);
    srcVec = 8'h00;
    ticks(4);

    ticks(1);
    finished = 1'b1;
    #(CLK_P);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule